// File: doc/BRIEF.md
# Carry-Select ALU Datapath

A purely combinational arithmetic and logic unit whose width is a parameter, a positive multiple of 8 that defaults to 32. A 3-bit operation code selects one of six functions: complement of operand A, bitwise AND, bitwise OR, bitwise XOR, addition and subtraction. Only a carry-out comes with the result. No other flags are produced.

The adder is built from 8-bit ripple segments. The lowest segment ripples from the real incoming carry. Every segment above it is evaluated twice, once for an incoming carry of 0 and once for 1. The resolved carry from the segment below then picks one of the two pairs through an AND-OR select. Each segment therefore adds only a two-level select to the critical path instead of a full 8-bit ripple.

Subtraction inverts operand A, not B, and forces a carry of 1 into bit 0. The adder thus returns B minus A in two's complement.

Top module: `csel_alu`

## Requirements
- R1: Opcode 0 (NOT) drives result = ~A and carry-out = 0.
- R2: Opcodes 1, 2 and 3 (AND, OR, XOR) drive the bitwise AND, OR and XOR of A and B, with carry-out = 0.
- R3: Opcode 4 (ADD) drives result = (A + B + cin) mod 2^WIDTH, with carry-out equal to bit WIDTH of that sum.
- R4: Opcode 5 (SUB) drives result = (B - A) mod 2^WIDTH, with carry-out = 1 exactly when B >= A unsigned. cin has no effect on either output.
- R5: A carry produced in any 8-bit segment reaches every segment above it, including a chain through all segments to carry-out.
- R6: Opcodes 6 and 7 drive result = 0 and carry-out = 0.
- R7: For opcodes 0 to 3, cin has no effect on the outputs. For opcode 0, B also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A (complemented by NOT, subtrahend for SUB) |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry into ADD |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Result |
| carry_o | output | 1 | Carry-out (arithmetic only) |

## Verification
The bench aims at carries that are born in one segment and must flip the select of every segment above it. These come from operands such as all-ones plus one and from low-byte fills plus one at each boundary. A wrong select polarity or a broken carry chain would show up as a zeroed or stale upper byte.

Subtraction is run with B below, equal to and above A, and with cin at both values. Inverting the wrong operand would return A minus B. Dropping the forced carry would give results one too small. Letting cin leak in would change the result depending on cin.

The logic operations and the unused opcodes are run with cin set and random B, so that a stray carry-out or a leaking input shows up at the outputs.

// File: rtl/csel_alu_pkg.sv
package csel_alu_pkg;
  localparam int unsigned SEG_W = 8;

  typedef enum logic [2:0] {
    OP_NOT = 3'd0,
    OP_AND = 3'd1,
    OP_OR  = 3'd2,
    OP_XOR = 3'd3,
    OP_ADD = 3'd4,
    OP_SUB = 3'd5
  } alu_op_e;
endpackage

// File: rtl/csel_seg_ripple.sv
// One ripple segment; sub conditions operand A.
module csel_seg_ripple #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0]   c;
  logic [W-1:0] a_c, p;

  assign a_c  = a_i ^ {W{sub_i}};
  assign p    = a_c ^ b_i;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = p[i] ^ c[i];
    assign c[i+1]   = (p[i] & c[i]) | (a_c[i] & b_i[i]);
  end

  assign cout_o = c[W];
endmodule

// File: rtl/csel_seg_select.sv
// Upper segment: both carry cases precomputed, AND-OR selected.
module csel_seg_select #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] sum0, sum1;
  logic         co0, co1;

  csel_seg_ripple #(.W(W)) u_c0 (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i), .cin_i(1'b0), .sum_o(sum0), .cout_o(co0)
  );
  csel_seg_ripple #(.W(W)) u_c1 (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i), .cin_i(1'b1), .sum_o(sum1), .cout_o(co1)
  );

  assign sum_o  = (sum1 & {W{cin_i}}) | (sum0 & {W{~cin_i}});
  assign cout_o = (co1 & cin_i) | (co0 & ~cin_i);
endmodule

// File: rtl/csel_alu.sv
module csel_alu #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  import csel_alu_pkg::*;

  localparam int unsigned NSEG = WIDTH / SEG_W;

  if ((WIDTH % SEG_W) != 0 || WIDTH == 0) begin : g_bad_width
    $error("WIDTH must be a positive multiple of 8");
  end

  alu_op_e          op;
  logic             sub;
  logic [NSEG:0]    seg_c;
  logic [WIDTH-1:0] sum;

  assign op       = alu_op_e'(op_i);
  assign sub      = (op == OP_SUB);
  assign seg_c[0] = cin_i | sub;

  csel_seg_ripple #(.W(SEG_W)) u_seg0 (
    .a_i   (a_i[SEG_W-1:0]),
    .b_i   (b_i[SEG_W-1:0]),
    .sub_i (sub),
    .cin_i (seg_c[0]),
    .sum_o (sum[SEG_W-1:0]),
    .cout_o(seg_c[1])
  );

  for (genvar k = 1; k < NSEG; k++) begin : g_seg
    csel_seg_select #(.W(SEG_W)) u_sel (
      .a_i   (a_i[k*SEG_W +: SEG_W]),
      .b_i   (b_i[k*SEG_W +: SEG_W]),
      .sub_i (sub),
      .cin_i (seg_c[k]),
      .sum_o (sum[k*SEG_W +: SEG_W]),
      .cout_o(seg_c[k+1])
    );
  end

  always_comb begin
    result_o = '0;
    carry_o  = 1'b0;
    unique case (op)
      OP_NOT: result_o = ~a_i;
      OP_AND: result_o = a_i & b_i;
      OP_OR:  result_o = a_i | b_i;
      OP_XOR: result_o = a_i ^ b_i;
      OP_ADD, OP_SUB: begin
        result_o = sum;
        carry_o  = seg_c[NSEG];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/csel_alu_chk.sv
module csel_alu_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o
);
  logic [WIDTH:0] ref_add, ref_sub;

  always_comb begin
    ref_add = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    ref_sub = {1'b0, b_i} + {1'b0, ~a_i} + {{WIDTH{1'b0}}, 1'b1};
    if (op_i == 3'd0) begin
      p_not_r1: assert (result_o == ~a_i && !carry_o) else $error("p_not_r1");
    end
    if (op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd3) begin
      p_logic_nocarry_r2: assert (!carry_o) else $error("p_logic_nocarry_r2");
    end
    if (op_i == 3'd3) begin
      p_xor_r2: assert (result_o == (a_i ^ b_i)) else $error("p_xor_r2");
    end
    if (op_i == 3'd4) begin
      p_add_r3: assert ({carry_o, result_o} == ref_add) else $error("p_add_r3");
    end
    if (op_i == 3'd5) begin
      p_sub_r4: assert ({carry_o, result_o} == ref_sub) else $error("p_sub_r4");
      p_sub_borrow_r4: assert (carry_o == (b_i >= a_i)) else $error("p_sub_borrow_r4");
    end
    if (op_i == 3'd6 || op_i == 3'd7) begin
      p_unused_zero_r6: assert (result_o == '0 && !carry_o) else $error("p_unused_zero_r6");
    end
  end
endmodule

bind csel_alu csel_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .op_i(op_i),
  .result_o(result_o), .carry_o(carry_o)
);

// File: tb/csel_alu_test.sv
module csel_alu_test;
  localparam int unsigned WIDTH = 32;
  localparam int unsigned NSEG  = WIDTH / 8;

  typedef struct {
    logic [WIDTH-1:0] res;
    logic             co;
    string            req;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [WIDTH-1:0] a, b, res;
  logic             cin, co;
  logic [2:0]       op;
  int               n_chk = 0, n_err = 0;
  bit               done = 1'b0;
  exp_t             q[$];

  csel_alu #(.WIDTH(WIDTH)) uut (
    .a_i(a), .b_i(b), .cin_i(cin), .op_i(op), .result_o(res), .carry_o(co)
  );

  function automatic exp_t model(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y,
                                 logic c, logic [2:0] o, string req);
    exp_t e;
    logic [WIDTH:0] s;
    e.req = req;
    e.co  = 1'b0;
    e.res = '0;
    case (o)
      3'd0: e.res = ~x;
      3'd1: e.res = x & y;
      3'd2: e.res = x | y;
      3'd3: e.res = x ^ y;
      3'd4: begin s = {1'b0, x} + {1'b0, y} + (WIDTH+1)'(c); e.res = s[WIDTH-1:0]; e.co = s[WIDTH]; end
      3'd5: begin e.res = y - x; e.co = (y >= x); end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y,
                       logic c, logic [2:0] o, string req);
    @(posedge clk);
    #1;
    a = x; b = y; cin = c; op = o;
    q.push_back(model(x, y, c, o, req));
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (res !== e.res || co !== e.co) begin
          n_err++;
          $display("FAIL %s: op=%0d got res=%h co=%b exp res=%h co=%b",
                   e.req, op, res, co, e.res, e.co);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] alt;
    alt = {(WIDTH/2){2'b10}};
    a = '0; b = '0; cin = 1'b0; op = 3'd0;
    // initial state: NOT of zero
    drive('0, '0, 1'b0, 3'd0, "R1 init");
    drive(alt, '1, 1'b1, 3'd0, "R1 R7 not alt");
    drive('1, alt, 1'b1, 3'd0, "R1 R7 not ones");
    drive(alt, ~alt, 1'b1, 3'd1, "R2 R7 and");
    drive(alt, ~alt, 1'b1, 3'd2, "R2 R7 or");
    drive(alt, alt, 1'b1, 3'd3, "R2 R7 xor");
    drive('1, '1, 1'b0, 3'd4, "R3 add ones");
    drive('0, '0, 1'b1, 3'd4, "R3 add cin");
    drive('1, '0, 1'b1, 3'd4, "R5 full chain");
    drive('1, '1, 1'b1, 3'd4, "R5 full chain max");
    for (int k = 1; k < int'(NSEG); k++) begin
      drive((WIDTH'(1) << (8*k)) - 1, WIDTH'(1), 1'b0, 3'd4, "R5 boundary");
      drive((WIDTH'(1) << (8*k)) - 1, '0, 1'b1, 3'd4, "R5 boundary cin");
      drive(WIDTH'(1) << (8*k), '0, 1'b0, 3'd5, "R5 R4 borrow chain");
    end
    drive(alt, alt, 1'b0, 3'd5, "R4 equal");
    drive(alt, alt, 1'b1, 3'd5, "R4 equal cin");
    drive(WIDTH'(5), WIDTH'(3), 1'b0, 3'd5, "R4 b<a");
    drive(WIDTH'(3), WIDTH'(5), 1'b1, 3'd5, "R4 b>a cin");
    drive('0, '1, 1'b0, 3'd5, "R4 max");
    drive('1, '0, 1'b1, 3'd5, "R4 min");
    drive(alt, '1, 1'b1, 3'd6, "R6 op6");
    drive('1, alt, 1'b0, 3'd7, "R6 op7");
    for (int i = 0; i < 300; i++) begin
      logic [WIDTH-1:0] x, y;
      logic [2:0] o;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      o = 3'($urandom_range(7));
      drive(x, y, 1'($urandom), o,
            o == 3'd0 ? "R1 rnd" : o <= 3'd3 ? "R2 rnd" : o == 3'd4 ? "R3 rnd" :
            o == 3'd5 ? "R4 rnd" : "R6 rnd");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule